// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Tracker

This block sits beside a memory controller and watches the decoded command stream sent to a two-bank synchronous DRAM. For each presented command it decides, in the same cycle, whether that command is legal given the current state of both banks and the cycles elapsed since earlier commands. It keeps each bank's state and per-bank cycle counters, flags any illegal command with a one-cycle pulse and a code naming the broken rule, and warns when an open row approaches its longest allowed active time.

All timing limits are integer cycle counts supplied as parameters, already converted from nanoseconds by rounding up to whole clock periods. Counters saturate at the largest value they are compared against. The tracker neither drives the memory pins nor schedules refresh. It only checks and tracks.

Top module: `sdram2_cmd_tracker`

## Requirements
- R1: After reset both banks report idle (state code 0), `viol` and both warning flags are low, and with no valid command `cmd_ok` is high.
- R2: Activate (op 1) is legal only on an idle bank (otherwise code 1). An activate to the other bank than the most recent activate needs at least T_RRD cycles since that activate (otherwise code 2). Bank states appear on `bank_state`, bank 0 in bits [1:0]: 0 idle, 1 active, 2 auto-precharging, 3 precharging.
- R3: Read (op 2) and write (op 3) need the bank active (otherwise code 1) and at least T_RCD cycles since its activate (otherwise code 3).
- R4: Precharge (op 4) needs the bank active (otherwise code 1) and at least T_RAS_MIN cycles since its activate (otherwise code 4). It moves the bank to precharging.
- R5: A precharged bank reports idle T_RP cycles after the precharge command, and a new activate to it is legal from that cycle on.
- R6: Read or write with `cmd_ap` high moves the bank to auto-precharging. At cycle max(command+BURST_LEN, activate+T_RAS_MIN) the bank starts precharging and becomes idle T_RP cycles later. Any command to an auto-precharging bank is rejected with code 6.
- R7: Auto refresh (op 6) and mode register set (op 7) are legal only when both banks are idle (otherwise code 5).
- R8: Precharge-all (op 5) needs every active bank to have met T_RAS_MIN (otherwise code 4), and both banks report idle T_RP cycles after it.
- R9: While a bank is active, `ras_warn` is high when its cycles since activate lie in [T_RAS_MAX-WARN_MARGIN, T_RAS_MAX], and `ras_expired` is high once they exceed T_RAS_MAX.
- R10: An illegal command drops `cmd_ok` combinationally, leaves all bank states unchanged, and raises `viol` for exactly the next cycle with its code on `viol_code` (0 when legal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command opcode (0 nop … 7 mode set) |
| cmd_bank | input | 1 | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for read/write |
| cmd_ok | output | 1 | Presented command is legal now |
| viol | output | 1 | One-cycle pulse after an illegal command |
| viol_code | output | 3 | Rule broken by the last command |
| bank_state | output | 4 | Two-bit state per bank |
| ras_warn | output | 2 | Per-bank near-maximum-active warning |
| ras_expired | output | 2 | Per-bank active-time limit exceeded |

## Verification
A wrong counter or state in this tracker surfaces at `cmd_ok` at the very cycle a timed command is probed, so the bench sweeps the gap between an activate or precharge and the next command one cycle at a time across each threshold. State errors show on `bank_state` in the same cycle, and the auto-precharge schedule is followed cycle by cycle from its computed start until the bank is idle. A mis-registered violation shows one cycle later on `viol` and `viol_code`.

// File: rtl/sdram2_cmd_tracker.sv
module sdram2_cmd_tracker #(
  parameter int T_RRD       = 2,
  parameter int T_RCD       = 3,
  parameter int T_RAS_MIN   = 6,
  parameter int T_RAS_MAX   = 20,
  parameter int T_RP        = 3,
  parameter int BURST_LEN   = 4,
  parameter int WARN_MARGIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_bank,
  input  logic       cmd_ap,
  output logic       cmd_ok,
  output logic       viol,
  output logic [2:0] viol_code,
  output logic [3:0] bank_state,
  output logic [1:0] ras_warn,
  output logic [1:0] ras_expired
);

  localparam int M1 = (T_RAS_MAX + 1 > BURST_LEN) ? T_RAS_MAX + 1 : BURST_LEN;
  localparam int M2 = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3 = (M2 > T_RRD) ? M2 : T_RRD;
  localparam int CW = $clog2(M3 + 1);
  localparam int PSAT = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;

  localparam logic [CW-1:0] C_RRD   = CW'(T_RRD);
  localparam logic [CW-1:0] C_RCD   = CW'(T_RCD);
  localparam logic [CW-1:0] C_RMIN  = CW'(T_RAS_MIN);
  localparam logic [CW-1:0] C_RMAX  = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] C_ASAT  = CW'(T_RAS_MAX + 1);
  localparam logic [CW-1:0] C_RP    = CW'(T_RP);
  localparam logic [CW-1:0] C_BL    = CW'(BURST_LEN);
  localparam logic [CW-1:0] C_PSAT  = CW'(PSAT);
  localparam logic [CW-1:0] C_WARN  = CW'(T_RAS_MAX - WARN_MARGIN);
  localparam logic [CW-1:0] C_ONE   = CW'(1);

  localparam logic [2:0] OP_ACT  = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_WR   = 3'd3;
  localparam logic [2:0] OP_PRE  = 3'd4;
  localparam logic [2:0] OP_PREA = 3'd5;
  localparam logic [2:0] OP_REF  = 3'd6;
  localparam logic [2:0] OP_MRS  = 3'd7;

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ACT  = 2'd1;
  localparam logic [1:0] S_APRE = 2'd2;
  localparam logic [1:0] S_PRE  = 2'd3;

  localparam logic [2:0] V_NONE = 3'd0;
  localparam logic [2:0] V_BUSY = 3'd1;
  localparam logic [2:0] V_RRD  = 3'd2;
  localparam logic [2:0] V_RCD  = 3'd3;
  localparam logic [2:0] V_RAS  = 3'd4;
  localparam logic [2:0] V_GLOB = 3'd5;
  localparam logic [2:0] V_LOCK = 3'd6;

  logic [1:0][1:0]    st, es;
  logic [1:0][CW-1:0] act_cnt, pc_cnt;
  logic [1:0]         ap_done, take_act, take_pre, take_apre;
  logic [CW-1:0]      rrd_cnt;
  logic               last_b;
  logic [2:0]         code;
  logic [1:0]         tgt_st;
  logic [CW-1:0]      tgt_cnt;

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      es[g]      = (st[g] == S_PRE && pc_cnt[g] >= C_RP) ? S_IDLE : st[g];
      ap_done[g] = (st[g] == S_APRE) && (pc_cnt[g] >= C_BL) && (act_cnt[g] >= C_RMIN);
    end
  end

  assign tgt_st  = es[cmd_bank];
  assign tgt_cnt = act_cnt[cmd_bank];

  always_comb begin
    code = V_NONE;
    unique case (cmd_op)
      OP_ACT:
        if (tgt_st == S_APRE)                          code = V_LOCK;
        else if (tgt_st != S_IDLE)                     code = V_BUSY;
        else if (last_b != cmd_bank && rrd_cnt < C_RRD) code = V_RRD;
      OP_RD, OP_WR:
        if (tgt_st == S_APRE)      code = V_LOCK;
        else if (tgt_st != S_ACT)  code = V_BUSY;
        else if (tgt_cnt < C_RCD)  code = V_RCD;
      OP_PRE:
        if (tgt_st == S_APRE)      code = V_LOCK;
        else if (tgt_st != S_ACT)  code = V_BUSY;
        else if (tgt_cnt < C_RMIN) code = V_RAS;
      OP_PREA:
        if (es[0] == S_APRE || es[1] == S_APRE)     code = V_LOCK;
        else if (es[0] == S_PRE || es[1] == S_PRE)  code = V_BUSY;
        else if ((es[0] == S_ACT && act_cnt[0] < C_RMIN) ||
                 (es[1] == S_ACT && act_cnt[1] < C_RMIN)) code = V_RAS;
      OP_REF, OP_MRS:
        if (es[0] != S_IDLE || es[1] != S_IDLE) code = V_GLOB;
      default: ;
    endcase
    if (!cmd_valid) code = V_NONE;
  end

  assign cmd_ok = (code == V_NONE);

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      take_act[g]  = cmd_valid && cmd_ok && cmd_op == OP_ACT && cmd_bank == 1'(g);
      take_pre[g]  = cmd_valid && cmd_ok &&
                     ((cmd_op == OP_PRE && cmd_bank == 1'(g)) ||
                      (cmd_op == OP_PREA && es[g] == S_ACT));
      take_apre[g] = cmd_valid && cmd_ok && cmd_ap && cmd_bank == 1'(g) &&
                     (cmd_op == OP_RD || cmd_op == OP_WR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      act_cnt <= '0;
      pc_cnt  <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (act_cnt[g] < C_ASAT) act_cnt[g] <= act_cnt[g] + C_ONE;
        if (pc_cnt[g] < C_PSAT)  pc_cnt[g]  <= pc_cnt[g] + C_ONE;
        if (take_act[g]) begin
          st[g]      <= S_ACT;
          act_cnt[g] <= C_ONE;
        end else if (take_pre[g] || ap_done[g]) begin
          st[g]     <= S_PRE;
          pc_cnt[g] <= C_ONE;
        end else if (take_apre[g]) begin
          st[g]     <= S_APRE;
          pc_cnt[g] <= C_ONE;
        end else begin
          st[g] <= es[g];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_cnt <= C_RRD;
      last_b  <= 1'b0;
    end else if (take_act != 2'b00) begin
      rrd_cnt <= C_ONE;
      last_b  <= cmd_bank;
    end else if (rrd_cnt < C_RRD) begin
      rrd_cnt <= rrd_cnt + C_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= V_NONE;
    end else begin
      viol      <= cmd_valid && !cmd_ok;
      viol_code <= code;
    end
  end

  assign bank_state = {es[1], es[0]};

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      ras_expired[g] = (es[g] == S_ACT) && (act_cnt[g] > C_RMAX);
      ras_warn[g]    = (es[g] == S_ACT) && (act_cnt[g] >= C_WARN) && (act_cnt[g] <= C_RMAX);
    end
  end

  AST_VIOL_AFTER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> ($past(cmd_valid) && !$past(cmd_ok))); // R10

  AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ok && (cmd_op == OP_REF || cmd_op == OP_MRS)) |-> (bank_state == 4'd0)); // R7

  for (genvar g = 0; g < 2; g++) begin : g_bank_chk
    AST_ACT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == S_ACT && $past(st[g]) != S_ACT) |->
        $past(cmd_valid && cmd_ok && cmd_op == OP_ACT && cmd_bank == 1'(g))); // R2

    AST_APRE_NO_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == S_APRE) |=> (st[g] == S_APRE || st[g] == S_PRE)); // R6

    AST_PRE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == S_PRE && es[g] == S_IDLE) |=> (st[g] == S_IDLE || st[g] == S_ACT)); // R5

    AST_EXPIRE_AFTER_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_expired[g]) |-> $past(ras_warn[g])); // R9
  end

endmodule

// File: tb/sdram2_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram2_cmd_tracker_tb_top;
  localparam int RRD = 2, RCD = 3, RMIN = 6, RMAX = 20, RP = 3, BL = 4, WM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       cmd_bank = 1'b0;
  logic       cmd_ap = 1'b0;
  logic       cmd_ok, viol;
  logic [2:0] viol_code;
  logic [3:0] bank_state;
  logic [1:0] ras_warn, ras_expired;

  int n_tests = 0;
  int n_fail  = 0;
  logic ok_s;

  always #2.5 clk = ~clk;

  sdram2_cmd_tracker #(.T_RRD(RRD), .T_RCD(RCD), .T_RAS_MIN(RMIN), .T_RAS_MAX(RMAX),
                       .T_RP(RP), .BURST_LEN(BL), .WARN_MARGIN(WM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_ok(cmd_ok), .viol(viol),
    .viol_code(viol_code), .bank_state(bank_state), .ras_warn(ras_warn),
    .ras_expired(ras_expired));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic b, input logic ap);
    cmd_valid = (op != 3'd0);
    cmd_op = op; cmd_bank = b; cmd_ap = ap;
    #1 ok_s = cmd_ok;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_ap = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(3'd0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 state", bank_state, 0);
    chk("R1 viol", viol, 0);
    chk("R1 warn", ras_warn | ras_expired, 0);
    #1 chk("R1 ok idle", cmd_ok, 1);
    @(negedge clk);

    // R3 tRCD sweep
    for (int d = 1; d <= 6; d++) begin
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(d - 1);
      issue((d % 2 == 0) ? 3'd3 : 3'd2, 1'b0, 1'b0);
      chk("R3 ok", ok_s, d >= RCD);
      chk("R3 code", viol_code, (d >= RCD) ? 0 : 3);
      chk("R10 state kept", bank_state[1:0], 1);
    end
    do_reset();
    issue(3'd2, 1'b1, 1'b0);
    chk("R3 idle bank code", viol_code, 1);
    chk("R10 pulse", viol, 1);
    nops(1);
    chk("R10 pulse one cycle", viol, 0);

    // R4 tRAS(min) sweep
    for (int d = 1; d <= 8; d++) begin
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(d - 1);
      issue(3'd4, 1'b0, 1'b0);
      chk("R4 ok", ok_s, d >= RMIN);
      chk("R4 code", viol_code, (d >= RMIN) ? 0 : 4);
      chk("R4 state", bank_state[1:0], (d >= RMIN) ? 3 : 1);
    end

    // R5 precharge to idle
    do_reset();
    issue(3'd1, 1'b0, 1'b0); nops(RMIN - 1); issue(3'd4, 1'b0, 1'b0);
    for (int k = 1; k <= RP + 1; k++) begin
      chk("R5 state", bank_state[1:0], (k >= RP) ? 0 : 3);
      nops(1);
    end
    for (int d = 1; d <= 4; d++) begin
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(RMIN - 1); issue(3'd4, 1'b0, 1'b0);
      nops(d - 1);
      issue(3'd1, 1'b0, 1'b0);
      chk("R5 reactivate", ok_s, d >= RP);
    end

    // R2 cross-bank spacing
    for (int d = 1; d <= 4; d++) begin
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(d - 1);
      issue(3'd1, 1'b1, 1'b0);
      chk("R2 ok", ok_s, d >= RRD);
      chk("R2 code", viol_code, (d >= RRD) ? 0 : 2);
      chk("R2 bank1 state", bank_state[3:2], (d >= RRD) ? 1 : 0);
    end
    do_reset();
    issue(3'd1, 1'b0, 1'b0); issue(3'd1, 1'b0, 1'b0);
    chk("R2 active bank code", viol_code, 1);

    // R6 auto-precharge schedule and lock
    for (int rd = RCD; rd <= RCD + 3; rd++) begin
      int t;
      int e;
      t = (rd + BL > RMIN) ? rd + BL : RMIN;
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(rd - 1);
      issue(3'd2, 1'b0, 1'b1);
      for (int k = rd + 1; k <= t + RP; k++) begin
        e = (k <= t) ? 2 : ((k < t + RP) ? 3 : 0);
        chk("R6 state", bank_state[1:0], e);
        if (e != 0) begin
          issue(3'd2, 1'b0, 1'b0);
          chk("R6 probe ok", ok_s, 0);
          chk("R6 probe code", viol_code, (e == 2) ? 6 : 1);
        end
      end
    end

    // R7 global commands
    do_reset();
    issue(3'd1, 1'b0, 1'b0);
    issue(3'd6, 1'b0, 1'b0);
    chk("R7 ref busy", viol_code, 5);
    issue(3'd7, 1'b0, 1'b0);
    chk("R7 mrs busy", ok_s, 0);
    do_reset();
    issue(3'd6, 1'b0, 1'b0);
    chk("R7 ref idle", ok_s, 1);
    issue(3'd7, 1'b1, 1'b0);
    chk("R7 mrs idle", ok_s, 1);

    // R8 precharge-all
    for (int d = 3; d <= 8; d++) begin
      do_reset();
      issue(3'd1, 1'b0, 1'b0); nops(1); issue(3'd1, 1'b1, 1'b0);
      nops(d - 1);
      issue(3'd5, 1'b0, 1'b0);
      chk("R8 ok", ok_s, d >= RMIN);
      chk("R8 code", viol_code, (d >= RMIN) ? 0 : 4);
      if (d >= RMIN) begin
        chk("R8 both precharging", bank_state, 4'hF);
        nops(RP - 1);
        chk("R8 both idle", bank_state, 0);
      end
    end

    // R9 active-time window
    do_reset();
    issue(3'd1, 1'b0, 1'b0);
    for (int k = 1; k <= RMAX + 4; k++) begin
      chk("R9 warn", ras_warn[0], (k >= RMAX - WM) && (k <= RMAX));
      chk("R9 expired", ras_expired[0], k > RMAX);
      chk("R9 other bank", {ras_warn[1], ras_expired[1]}, 0);
      nops(1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule